// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block holds the impedance code applied to a memory's data output drivers and walks it toward a target code. The target comes from an external reference measurement and arrives already digitised. If the reference pin is found open or tied to the output supply, the target is replaced by the maximum-impedance code. After reset the drivers start at the minimum-impedance code, which is code zero.

A driver must never change strength while it is driving a value. The code therefore moves only in clock cycles where the memory pipeline reports its outputs undriven. Three conditions give such a cycle: a write cycle, a deselect cycle, or the output enable held inactive across the clock edge.

Update opportunities pass through a slew divider. The code moves one step toward the target on every `STEP_DIV`-th opportunity and stops when it reaches the target. `STEP_DIV` is set so that a full sweep from code 0 to the maximum code takes no more than `UPDATES_FULL` opportunities. A done flag reports that the applied code has reached the effective target.

Top module: `drv_imp_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `drv_code` becomes 0, the minimum-impedance code. The registered effective target also clears, so `done` reads 1 right after reset.
- R2: `drv_code` changes only at a clock edge where at least one of `wr_cycle`, `desel_cycle` or `oe_off` is high. With all three low it holds, for any number of cycles and any target.
- R3: Each of `wr_cycle`, `desel_cycle` and `oe_off` counts as an update opportunity on its own.
- R4: When `ref_open` or `ref_high` is high, the effective target is all ones (the maximum-impedance code), whatever the value of `target_code`.
- R5: `drv_code` changes by exactly one per step, upward when the effective target is above it and downward when it is below, and it never passes the target.
- R6: While `drv_code` differs from the effective target, a step happens on every `STEP_DIV`-th opportunity, where `STEP_DIV = UPDATES_FULL >> CODE_W` (64 by default). The opportunity count clears whenever the code equals the target. A full sweep from 0 to all ones therefore takes (2^CODE_W - 1) * STEP_DIV opportunities, which is 4032 by default and no more than 4096.
- R7: `done` is 1 exactly when `drv_code` equals the registered effective target. While it is 1, opportunities leave `drv_code` unchanged.
- R8: The target inputs (`target_code`, `ref_open`, `ref_high`) are registered at every clock edge, so `done` and the step direction respond to a change one edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| target_code | input | CODE_W | Measured target impedance code (0 = minimum impedance) |
| ref_open | input | 1 | Reference pin detected open |
| ref_high | input | 1 | Reference pin detected tied to the output supply |
| wr_cycle | input | 1 | Pipeline is in a write cycle; outputs undriven |
| desel_cycle | input | 1 | Pipeline is in a deselect cycle; outputs undriven |
| oe_off | input | 1 | Output enable inactive across this edge; outputs undriven |
| drv_code | output | CODE_W | Impedance code applied to the output drivers |
| done | output | 1 | Applied code equals the effective target |

## Verification
The assertions assume that the three undriven indications and the reference flags are clean synchronous levels that are valid at the sampling edge. They also assume that reset is held low for at least one edge before operation starts, so that every history term begins from a known code. The bench drives all inputs on the falling clock edge and holds them stable across the rising edge, with reset asserted from time zero. It changes the target only in cycles with no opportunity pending, so each step can be tied to a known opportunity count.

// File: rtl/drv_imp_pkg.sv
// Shared types for the output driver impedance sequencer.
// Assumes: code 0 is minimum impedance and all ones is maximum impedance.
package drv_imp_pkg;
    // Direction chosen for the next step of the applied code.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_t;
endpackage

// File: rtl/drv_imp_target.sv
// Effective target register: substitutes the maximum-impedance code when
// the reference pin is open or tied high, and registers the result so that
// the stepper works from a stable target.
// Assumes: the inputs are synchronous to clk.
module drv_imp_target #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] target_code,
    input  logic              ref_open,
    input  logic              ref_high,
    output logic [CODE_W-1:0] tgt_q
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    logic [CODE_W-1:0] tgt_d;

    // Pick the forced maximum code when the reference is unusable.
    always_comb begin
        if (ref_open || ref_high) begin
            tgt_d = MAX_CODE;
        end else begin
            tgt_d = target_code;
        end
    end

    // Register the effective target; clears to minimum impedance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            tgt_q <= tgt_d;
        end
    end
endmodule

// File: rtl/drv_imp_slew.sv
// Slew divider: lets one step through for every STEP_DIV update
// opportunities seen while the code differs from the target. The count
// clears whenever the code matches the target.
// Assumes: STEP_DIV >= 1.
module drv_imp_slew #(
    parameter int STEP_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic opp,
    input  logic match,
    output logic step_ok
);
    localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

    generate
        if (STEP_DIV == 1) begin : g_nodiv
            // Every opportunity steps when no division is asked for.
            always_comb begin
                step_ok = opp && !match;
            end
        end else begin : g_div
            localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);
            logic [DIV_W-1:0] cnt_q;

            // Step on the last opportunity of each divider period.
            always_comb begin
                step_ok = opp && !match && (cnt_q == LAST);
            end

            // Count opportunities while mismatched; clear on match.
            always_ff @(posedge clk) begin
                if (!rst_n || match) begin
                    cnt_q <= '0;
                end else if (opp) begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/drv_imp_stepper.sv
// Code stepper: compares the applied code with the target, reports a match
// and moves the code by one toward the target when a step is allowed.
// Assumes: step_en is only raised while match is low.
module drv_imp_stepper
    import drv_imp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_q,
    input  logic              step_en,
    output logic [CODE_W-1:0] code_q,
    output logic              match
);
    step_dir_t dir;

    // Decide the step direction from the code/target comparison.
    always_comb begin
        if (tgt_q > code_q) begin
            dir = DIR_UP;
        end else if (tgt_q < code_q) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
        match = (dir == DIR_HOLD);
    end

    // Apply one step when allowed; reset to minimum impedance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (step_en) begin
            case (dir)
                DIR_UP:   code_q <= code_q + CODE_W'(1);
                DIR_DOWN: code_q <= code_q - CODE_W'(1);
                default:  code_q <= code_q;
            endcase
        end
    end
endmodule

// File: rtl/drv_imp_seq.sv
// Output driver impedance update sequencer (top). Merges the undriven
// indications into one update opportunity, registers the effective target,
// divides opportunities into steps and walks the applied code.
// Assumes: UPDATES_FULL >= 2**CODE_W; all inputs synchronous to clk.
module drv_imp_seq #(
    parameter int CODE_W       = 6,
    parameter int UPDATES_FULL = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] target_code,
    input  logic              ref_open,
    input  logic              ref_high,
    input  logic              wr_cycle,
    input  logic              desel_cycle,
    input  logic              oe_off,
    output logic [CODE_W-1:0] drv_code,
    output logic              done
);
    localparam int STEP_DIV = UPDATES_FULL >> CODE_W;

    logic [CODE_W-1:0] tgt_q;
    logic              opp;
    logic              match;
    logic              step_ok;

    // Any undriven cycle is an opportunity to retune the drivers.
    always_comb begin
        opp = wr_cycle || desel_cycle || oe_off;
    end

    drv_imp_target #(.CODE_W(CODE_W)) u_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .target_code (target_code),
        .ref_open    (ref_open),
        .ref_high    (ref_high),
        .tgt_q       (tgt_q)
    );

    drv_imp_slew #(.STEP_DIV(STEP_DIV)) u_slew (
        .clk     (clk),
        .rst_n   (rst_n),
        .opp     (opp),
        .match   (match),
        .step_ok (step_ok)
    );

    drv_imp_stepper #(.CODE_W(CODE_W)) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_q   (tgt_q),
        .step_en (step_ok),
        .code_q  (drv_code),
        .match   (match)
    );

    // Report convergence to the effective target.
    always_comb begin
        done = match;
    end
endmodule

// File: rtl/drv_imp_seq_chk.sv
// Port-level checker for drv_imp_seq, attached with bind.
// Assumes: reset is held low for at least one edge at start-up.
module drv_imp_seq_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] target_code,
    input logic              ref_open,
    input logic              ref_high,
    input logic              wr_cycle,
    input logic              desel_cycle,
    input logic              oe_off,
    input logic [CODE_W-1:0] drv_code,
    input logic              done
);
    logic seen_rst;

    // Note that a reset edge has occurred, so history terms are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
        end
    end

    AST_CHANGE_ONLY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (drv_code != $past(drv_code)) |-> $past(wr_cycle || desel_cycle || oe_off)); // R2

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (drv_code != $past(drv_code)) |->
            ((drv_code == $past(drv_code) + CODE_W'(1)) || (drv_code == $past(drv_code) - CODE_W'(1)))); // R5

    AST_HOLD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        $past(done) |-> $stable(drv_code)); // R7

    AST_REF_FORCES_MAX: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        ($past(ref_open || ref_high) && done) |-> (drv_code == {CODE_W{1'b1}})); // R4

    AST_RESET_MIN: assert property (@(posedge clk) disable iff (!seen_rst)
        !$past(rst_n) |-> (drv_code == '0)); // R1
endmodule

bind drv_imp_seq drv_imp_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/drv_imp_seq_test.sv
module drv_imp_seq_test;
    localparam int W    = 6;
    localparam int DIV  = 4096 >> W;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] target_code = '0;
    logic         ref_open = 1'b0;
    logic         ref_high = 1'b0;
    logic         wr_cycle = 1'b0;
    logic         desel_cycle = 1'b0;
    logic         oe_off = 1'b0;
    logic [W-1:0] drv_code;
    logic         done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    drv_imp_seq uut (
        .clk(clk), .rst_n(rst_n), .target_code(target_code),
        .ref_open(ref_open), .ref_high(ref_high), .wr_cycle(wr_cycle),
        .desel_cycle(desel_cycle), .oe_off(oe_off),
        .drv_code(drv_code), .done(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Give n opportunities from source src (0 write, 1 deselect, 2 oe, 3 rotate).
    task automatic give_opps(input int n, input int src);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_cycle    = (src == 0) || (src == 3 && i % 3 == 0);
            desel_cycle = (src == 1) || (src == 3 && i % 3 == 1);
            oe_off      = (src == 2) || (src == 3 && i % 3 == 2);
        end
        @(negedge clk);
        wr_cycle = 1'b0; desel_cycle = 1'b0; oe_off = 1'b0;
    endtask

    task automatic set_target(input int t, input bit op, input bit hi);
        @(negedge clk);
        target_code = W'(t); ref_open = op; ref_high = hi;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after reset", drv_code, 0);
        chk("R1 done after reset", done, 1);
    endtask

    task automatic t_first_step();
        @(negedge clk);
        target_code = W'(5);
        chk("R8 done before target edge", done, 1);
        @(negedge clk);
        chk("R8 done one edge after target", done, 0);
        give_opps(DIV - 1, 0);
        chk("R6 no step before divider period", drv_code, 0);
        give_opps(1, 0);
        chk("R3 R5 write opportunity steps up", drv_code, 1);
    endtask

    task automatic t_idle_hold();
        repeat (50) @(negedge clk);
        chk("R2 no change without opportunity", drv_code, 1);
    endtask

    task automatic t_sources();
        give_opps(DIV, 1);
        chk("R3 deselect opportunity", drv_code, 2);
        give_opps(DIV, 2);
        chk("R3 output-enable opportunity", drv_code, 3);
        give_opps(2 * DIV, 3);
        chk("R5 reaches target", drv_code, 5);
        chk("R7 done at target", done, 1);
        give_opps(200, 3);
        chk("R7 holds at target", drv_code, 5);
    endtask

    task automatic t_ref_forced();
        set_target(2, 1'b1, 1'b0);
        chk("R4 open reference target above code", done, 0);
        give_opps((MAXC - 5) * DIV - 1, 0);
        chk("R6 one short of maximum", drv_code, MAXC - 1);
        give_opps(1, 0);
        chk("R4 open reference reaches maximum", drv_code, MAXC);
        chk("R4 done at maximum", done, 1);
        set_target(0, 1'b0, 1'b1);
        give_opps(300, 1);
        chk("R4 tied-high reference keeps maximum", drv_code, MAXC);
        chk("R4 done with tied-high reference", done, 1);
    endtask

    task automatic t_down_and_full();
        set_target(60, 1'b0, 1'b0);
        give_opps(3 * DIV, 2);
        chk("R5 steps down to target", drv_code, 60);
        set_target(0, 1'b0, 1'b0);
        give_opps(60 * DIV + 50, 0);
        chk("R5 no undershoot below zero target", drv_code, 0);
        set_target(MAXC, 1'b0, 1'b0);
        give_opps(MAXC * DIV - 1, 3);
        chk("R6 full sweep one short", drv_code, MAXC - 1);
        give_opps(1, 3);
        chk("R6 full sweep within budget", drv_code, MAXC);
        chk("R7 done after full sweep", done, 1);
    endtask

    initial begin
        t_reset();
        t_first_step();
        t_idle_hold();
        t_sources();
        t_ref_forced();
        t_down_and_full();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule